// File: doc/BRIEF.md
# AGP Status Decode and Read Return Tracker

This block sits on the bus-master side of an AGP 1.0 port. Each cycle it decodes the 3-bit status code from the core-logic arbiter, and only does so while the grant is asserted. It turns the code into one-cycle phase strobes for the rest of the master: low- or high-priority read return, low- or high-priority write-data request, and permission to start a bus operation. The master's request logic reports each pipelined read it enqueues through a strobe that carries the read's priority, its tag and its 3-bit length code. The tracker keeps the outstanding reads in two queues, one for each priority, and allows at most four reads in flight across both queues.

When a read return arrives, the tracker presents the tag of the oldest entry in the matching queue and retires that entry at the clock edge. The consumer reports how much space is left in its low-priority return buffer. From that figure the tracker drives the active-low read-buffer-full signal, which keeps the arbiter from returning low-priority data that the buffer cannot hold. The tracker records protocol violations in a sticky error flag. It flags a reserved status code with a separate single-cycle indication.

Top module: `agp_status_tracker`

## Requirements
- R1: While gnt_i is low, every phase strobe, rsvd_o and rd_tag_o stay low for all eight st_i values, and no queue entry is retired.
- R2: With gnt_i high, st_i=000 raises lo_rd_o alone and st_i=001 raises hi_rd_o alone, in the same cycle.
- R3: With gnt_i high, st_i=010 raises lo_wr_o alone and st_i=011 raises hi_wr_o alone, and neither affects the queues.
- R4: With gnt_i high, st_i=111 raises start_o alone.
- R5: With gnt_i high, st_i of 100, 101 or 110 raises rsvd_o for that cycle, raises no phase strobe, and leaves the queues unchanged.
- R6: An enqueue is accepted only while fewer than MAX_OUT (4) reads are outstanding across both priorities. pipe_full_o is high exactly when MAX_OUT reads are outstanding. An enqueue made while full is dropped and sets proto_err_o.
- R7: Within each priority, reads are retired in the order they were enqueued. During a return cycle rd_tag_o shows the tag of the oldest entry of that priority, and the entry is removed at the next clock edge. An enqueue in the same cycle is appended behind it.
- R8: A read return for a priority with no outstanding entry sets proto_err_o and shows rd_tag_o = 0.
- R9: rbf_no is driven low when buf_free_i (in 8-byte units) is less than the largest (length code + 1) among the outstanding low-priority reads. It is high whenever no low-priority read is outstanding. High-priority lengths never affect it.
- R10: A low-priority return that arrives while rbf_no is low sets proto_err_o. A high-priority return in the same situation does not.
- R11: After reset all strobes, rd_tag_o, pipe_full_o and proto_err_o are low and rbf_no is high. Once set, proto_err_o stays high until reset.
- R12: rd_tag_o is zero in every cycle that is not a read return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gnt_i | input | 1 | Arbiter grant, active high |
| st_i | input | 3 | Arbiter status code |
| enq_i | input | 1 | A read request is enqueued this cycle |
| enq_hi_i | input | 1 | Priority of the enqueued read (1 = high) |
| enq_len_i | input | LEN_W | Length code of the enqueued read (size = code + 1 units) |
| enq_tag_i | input | TAG_W | Tag of the enqueued read |
| buf_free_i | input | FREE_W | Free low-priority return buffer space, in 8-byte units |
| lo_rd_o | output | 1 | Low-priority read data is returned this cycle |
| hi_rd_o | output | 1 | High-priority read data is returned this cycle |
| lo_wr_o | output | 1 | Supply low-priority write data |
| hi_wr_o | output | 1 | Supply high-priority write data |
| start_o | output | 1 | Permission to start a bus operation |
| rsvd_o | output | 1 | Reserved code seen under grant |
| rd_tag_o | output | TAG_W | Tag of the read being returned |
| pipe_full_o | output | 1 | MAX_OUT reads outstanding |
| rbf_no | output | 1 | Read buffer full, active low |
| proto_err_o | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with its defaults: MAX_OUT=4, 4-bit tags, 3-bit length codes and a 5-bit free-space count. With a 5-bit count, buf_free_i can be driven from 0 to 31, which covers both sides of every threshold from 1 to 8. A depth of four lets all outstanding reads sit in one priority or be split between the two, so the tests reach overflow, retirement order inside each queue and push-with-pop in the same cycle. The directed phases reset the block between error scenarios, so that each way of setting the sticky flag is seen on its own. A long random phase then mixes grant, every status code, enqueues and buffer space.

// File: rtl/agp_trk_pkg.sv
package agp_trk_pkg;
  typedef enum logic [2:0] {
    ST_LO_RD = 3'b000,
    ST_HI_RD = 3'b001,
    ST_LO_WR = 3'b010,
    ST_HI_WR = 3'b011,
    ST_RSV4  = 3'b100,
    ST_RSV5  = 3'b101,
    ST_RSV6  = 3'b110,
    ST_START = 3'b111
  } agp_st_e;

  localparam int unsigned CLS_LO = 0;
  localparam int unsigned CLS_HI = 1;
  localparam int unsigned N_CLS  = 2;
endpackage

// File: rtl/agp_st_decode.sv
module agp_st_decode
  import agp_trk_pkg::*;
(
  input  logic       gnt_i,
  input  logic [2:0] st_i,
  output logic       lo_rd_o,
  output logic       hi_rd_o,
  output logic       lo_wr_o,
  output logic       hi_wr_o,
  output logic       start_o,
  output logic       rsvd_o
);
  agp_st_e st;
  assign st = agp_st_e'(st_i);

  always_comb begin
    lo_rd_o = 1'b0;
    hi_rd_o = 1'b0;
    lo_wr_o = 1'b0;
    hi_wr_o = 1'b0;
    start_o = 1'b0;
    rsvd_o  = 1'b0;
    if (gnt_i) begin
      unique case (st)
        ST_LO_RD: lo_rd_o = 1'b1;
        ST_HI_RD: hi_rd_o = 1'b1;
        ST_LO_WR: lo_wr_o = 1'b1;
        ST_HI_WR: hi_wr_o = 1'b1;
        ST_START: start_o = 1'b1;
        default:  rsvd_o  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/agp_rd_queues.sv
module agp_rd_queues
  import agp_trk_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TAG_W = 4,
  parameter int unsigned LEN_W = 3,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_CLS-1:0]             push_i,
  input  logic [TAG_W-1:0]             tag_i,
  input  logic [LEN_W-1:0]             len_i,
  input  logic [N_CLS-1:0]             pop_i,
  output logic [N_CLS-1:0][TAG_W-1:0]  head_tag_o,
  output logic [N_CLS-1:0][CNT_W-1:0]  cnt_o,
  output logic [DEPTH-1:0][LEN_W-1:0]  lo_len_o,
  output logic [DEPTH-1:0]             lo_vld_o
);
  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        cnt    <= '0;
        for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
      end else begin
        if (push_i[c]) begin
          tag_q[wr_ptr] <= tag_i;
          wr_ptr        <= nxt(wr_ptr);
        end
        if (pop_i[c]) rd_ptr <= nxt(rd_ptr);
        cnt <= cnt + CNT_W'(push_i[c]) - CNT_W'(pop_i[c]);
      end
    end

    assign head_tag_o[c] = tag_q[rd_ptr];
    assign cnt_o[c]      = cnt;

    // only the low-priority class needs lengths for buffer-full
    if (c == CLS_LO) begin : g_len
      logic [LEN_W-1:0] len_q [DEPTH];
      logic [DEPTH-1:0] vld_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q <= '0;
          for (int i = 0; i < DEPTH; i++) len_q[i] <= '0;
        end else begin
          if (pop_i[c]) vld_q[rd_ptr] <= 1'b0;
          if (push_i[c]) begin
            len_q[wr_ptr] <= len_i;
            vld_q[wr_ptr] <= 1'b1;
          end
        end
      end
      for (genvar i = 0; i < DEPTH; i++) begin : g_out
        assign lo_len_o[i] = len_q[i];
      end
      assign lo_vld_o = vld_q;
    end
  end
endmodule

// File: rtl/agp_rbf_calc.sv
module agp_rbf_calc #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned LEN_W  = 3,
  parameter int unsigned FREE_W = 5,
  localparam int unsigned NEED_W = LEN_W + 1,
  localparam int unsigned CMP_W  = (NEED_W > FREE_W) ? NEED_W : FREE_W
) (
  input  logic [DEPTH-1:0][LEN_W-1:0] len_i,
  input  logic [DEPTH-1:0]            vld_i,
  input  logic [FREE_W-1:0]           free_i,
  output logic                        rbf_no
);
  logic [NEED_W-1:0] need_max;

  always_comb begin
    need_max = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_i[i] && (NEED_W'(len_i[i]) + 1'b1) > need_max)
        need_max = NEED_W'(len_i[i]) + 1'b1;
    end
  end

  assign rbf_no = !(CMP_W'(free_i) < CMP_W'(need_max));
endmodule

// File: rtl/agp_status_tracker.sv
module agp_status_tracker
  import agp_trk_pkg::*;
#(
  parameter int unsigned MAX_OUT = 4,
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned LEN_W   = 3,
  parameter int unsigned FREE_W  = 5,
  localparam int unsigned CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gnt_i,
  input  logic [2:0]        st_i,
  input  logic              enq_i,
  input  logic              enq_hi_i,
  input  logic [LEN_W-1:0]  enq_len_i,
  input  logic [TAG_W-1:0]  enq_tag_i,
  input  logic [FREE_W-1:0] buf_free_i,
  output logic              lo_rd_o,
  output logic              hi_rd_o,
  output logic              lo_wr_o,
  output logic              hi_wr_o,
  output logic              start_o,
  output logic              rsvd_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              pipe_full_o,
  output logic              rbf_no,
  output logic              proto_err_o
);
  logic [N_CLS-1:0][TAG_W-1:0] head_tag;
  logic [N_CLS-1:0][CNT_W-1:0] cnt;
  logic [MAX_OUT-1:0][LEN_W-1:0] lo_len;
  logic [MAX_OUT-1:0]          lo_vld;
  logic [CNT_W-1:0]            lo_cnt, hi_cnt;
  logic [CNT_W:0]              total;
  logic                        accept, lo_empty, hi_empty, err_set, err_q;
  logic [N_CLS-1:0]            push, pop;

  agp_st_decode u_dec (
    .gnt_i   (gnt_i),
    .st_i    (st_i),
    .lo_rd_o (lo_rd_o),
    .hi_rd_o (hi_rd_o),
    .lo_wr_o (lo_wr_o),
    .hi_wr_o (hi_wr_o),
    .start_o (start_o),
    .rsvd_o  (rsvd_o)
  );

  assign lo_cnt   = cnt[CLS_LO];
  assign hi_cnt   = cnt[CLS_HI];
  assign total    = {1'b0, lo_cnt} + {1'b0, hi_cnt};
  assign lo_empty = (lo_cnt == '0);
  assign hi_empty = (hi_cnt == '0);
  assign pipe_full_o = (total == (CNT_W+1)'(MAX_OUT));
  assign accept   = enq_i && !pipe_full_o;

  always_comb begin
    push = '0;
    push[enq_hi_i ? CLS_HI : CLS_LO] = accept;
  end
  assign pop[CLS_LO] = lo_rd_o && !lo_empty;
  assign pop[CLS_HI] = hi_rd_o && !hi_empty;

  agp_rd_queues #(
    .DEPTH (MAX_OUT),
    .TAG_W (TAG_W),
    .LEN_W (LEN_W)
  ) u_q (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .tag_i      (enq_tag_i),
    .len_i      (enq_len_i),
    .pop_i      (pop),
    .head_tag_o (head_tag),
    .cnt_o      (cnt),
    .lo_len_o   (lo_len),
    .lo_vld_o   (lo_vld)
  );

  agp_rbf_calc #(
    .DEPTH  (MAX_OUT),
    .LEN_W  (LEN_W),
    .FREE_W (FREE_W)
  ) u_rbf (
    .len_i  (lo_len),
    .vld_i  (lo_vld),
    .free_i (buf_free_i),
    .rbf_no (rbf_no)
  );

  always_comb begin
    rd_tag_o = '0;
    if (pop[CLS_LO])      rd_tag_o = head_tag[CLS_LO];
    else if (pop[CLS_HI]) rd_tag_o = head_tag[CLS_HI];
  end

  assign err_set = (lo_rd_o && (lo_empty || !rbf_no)) ||
                   (hi_rd_o && hi_empty) ||
                   (enq_i && pipe_full_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end
  assign proto_err_o = err_q;
endmodule

// File: rtl/agp_status_tracker_chk.sv
module agp_status_tracker_chk #(
  parameter int unsigned MAX_OUT = 4,
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned CNT_W   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gnt_i,
  input logic             enq_i,
  input logic             enq_hi_i,
  input logic             lo_rd_o,
  input logic             hi_rd_o,
  input logic             lo_wr_o,
  input logic             hi_wr_o,
  input logic             start_o,
  input logic             rsvd_o,
  input logic [TAG_W-1:0] rd_tag_o,
  input logic             rbf_no,
  input logic             proto_err_o,
  input logic [CNT_W-1:0] lo_cnt,
  input logic [CNT_W-1:0] hi_cnt
);
  p_quiet_no_gnt_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_i |-> !(lo_rd_o || hi_rd_o || lo_wr_o || hi_wr_o || start_o || rsvd_o));

  p_one_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lo_rd_o, hi_rd_o, lo_wr_o, hi_wr_o, start_o, rsvd_o}));

  p_rsvd_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsvd_o && !enq_i) |=> (lo_cnt == $past(lo_cnt)) && (hi_cnt == $past(hi_cnt)));

  p_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, lo_cnt} + {1'b0, hi_cnt}) <= (CNT_W+1)'(MAX_OUT));

  p_overflow_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_i && ({1'b0, lo_cnt} + {1'b0, hi_cnt}) == (CNT_W+1)'(MAX_OUT)) |=> proto_err_o);

  p_lo_retire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_rd_o && lo_cnt != '0 && !(enq_i && !enq_hi_i)) |=> lo_cnt == $past(lo_cnt) - 1'b1);

  p_empty_ret_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_rd_o && hi_cnt == '0) |=> proto_err_o);

  p_rbf_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_cnt == '0) |-> rbf_no);

  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);

  p_tag_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lo_rd_o || hi_rd_o) |-> rd_tag_o == '0);
endmodule

bind agp_status_tracker agp_status_tracker_chk #(
  .MAX_OUT (MAX_OUT),
  .TAG_W   (TAG_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gnt_i       (gnt_i),
  .enq_i       (enq_i),
  .enq_hi_i    (enq_hi_i),
  .lo_rd_o     (lo_rd_o),
  .hi_rd_o     (hi_rd_o),
  .lo_wr_o     (lo_wr_o),
  .hi_wr_o     (hi_wr_o),
  .start_o     (start_o),
  .rsvd_o      (rsvd_o),
  .rd_tag_o    (rd_tag_o),
  .rbf_no      (rbf_no),
  .proto_err_o (proto_err_o),
  .lo_cnt      (lo_cnt),
  .hi_cnt      (hi_cnt)
);

// File: tb/agp_status_tracker_test.sv
`timescale 1ns/1ps
module agp_status_tracker_test;
  localparam int MAX_OUT = 4;
  localparam int TAG_W   = 4;
  localparam int LEN_W   = 3;
  localparam int FREE_W  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0, enq = 1'b0, enq_hi = 1'b0;
  logic [2:0] st = '0;
  logic [LEN_W-1:0] len = '0;
  logic [TAG_W-1:0] tag = '0;
  logic [FREE_W-1:0] free_sp = '0;
  logic lo_rd, hi_rd, lo_wr, hi_wr, start, rsvd, pfull, rbf_n, perr;
  logic [TAG_W-1:0] rtag;

  always #2 clk = ~clk;

  agp_status_tracker #(
    .MAX_OUT (MAX_OUT), .TAG_W (TAG_W), .LEN_W (LEN_W), .FREE_W (FREE_W)
  ) uut (
    .clk_i (clk), .rst_ni (rst_n), .gnt_i (gnt), .st_i (st),
    .enq_i (enq), .enq_hi_i (enq_hi), .enq_len_i (len), .enq_tag_i (tag),
    .buf_free_i (free_sp),
    .lo_rd_o (lo_rd), .hi_rd_o (hi_rd), .lo_wr_o (lo_wr), .hi_wr_o (hi_wr),
    .start_o (start), .rsvd_o (rsvd), .rd_tag_o (rtag),
    .pipe_full_o (pfull), .rbf_no (rbf_n), .proto_err_o (perr)
  );

  int vectors = 0;
  int fails = 0;
  string cur_req = "R11";
  int lo_tag_m[$], lo_need_m[$], hi_tag_m[$];
  bit err_m = 1'b0;

  task automatic cmp(string name, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, name, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    lo_tag_m.delete();
    lo_need_m.delete();
    hi_tag_m.delete();
    err_m = 1'b0;
  endtask

  task automatic apply(bit g, int s, bit e, bit eh, int l, int t, int f);
    bit e_lrd, e_hrd, e_lwr, e_hwr, e_st, e_rsv, e_full, e_rbf;
    int e_tag, need, total;
    @(negedge clk);
    gnt = g; st = 3'(s); enq = e; enq_hi = eh;
    len = LEN_W'(l); tag = TAG_W'(t); free_sp = FREE_W'(f);
    #1;
    e_lrd = g && s == 0;
    e_hrd = g && s == 1;
    e_lwr = g && s == 2;
    e_hwr = g && s == 3;
    e_st  = g && s == 7;
    e_rsv = g && s >= 4 && s <= 6;
    total = lo_tag_m.size() + hi_tag_m.size();
    e_full = total == MAX_OUT;
    need = 0;
    foreach (lo_need_m[i]) if (lo_need_m[i] > need) need = lo_need_m[i];
    e_rbf = !(f < need);
    e_tag = 0;
    if (e_lrd && lo_tag_m.size() > 0) e_tag = lo_tag_m[0];
    else if (e_hrd && hi_tag_m.size() > 0) e_tag = hi_tag_m[0];
    vectors++;
    cmp("lo_rd_o", lo_rd, e_lrd);
    cmp("hi_rd_o", hi_rd, e_hrd);
    cmp("lo_wr_o", lo_wr, e_lwr);
    cmp("hi_wr_o", hi_wr, e_hwr);
    cmp("start_o", start, e_st);
    cmp("rsvd_o", rsvd, e_rsv);
    cmp("rd_tag_o", rtag, e_tag);
    cmp("pipe_full_o", pfull, e_full);
    cmp("rbf_no", rbf_n, e_rbf);
    cmp("proto_err_o", perr, err_m);
    @(posedge clk);
    if ((e_lrd && (lo_tag_m.size() == 0 || !e_rbf)) ||
        (e_hrd && hi_tag_m.size() == 0) || (e && e_full)) err_m = 1'b1;
    if (e_lrd && lo_tag_m.size() > 0) begin
      void'(lo_tag_m.pop_front());
      void'(lo_need_m.pop_front());
    end
    if (e_hrd && hi_tag_m.size() > 0) void'(hi_tag_m.pop_front());
    if (e && !e_full) begin
      if (eh) hi_tag_m.push_back(t);
      else begin
        lo_tag_m.push_back(t);
        lo_need_m.push_back(l + 1);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    gnt = 0; enq = 0; st = '0;
    rst_n = 1'b0;
    #1;
    vectors++;
    cmp("lo_rd_o", lo_rd, 0);
    cmp("hi_rd_o", hi_rd, 0);
    cmp("start_o", start, 0);
    cmp("rd_tag_o", rtag, 0);
    cmp("pipe_full_o", pfull, 0);
    cmp("rbf_no", rbf_n, 1);
    cmp("proto_err_o", perr, 0);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(int f);
    apply(0, 0, 0, 0, 0, 0, f);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired in %s actual=running expected=done", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    cur_req = "R11";
    repeat (2) @(posedge clk);
    do_reset();
    idle(31);

    cur_req = "R4";
    apply(1, 7, 0, 0, 0, 0, 31);
    cur_req = "R3";
    apply(1, 2, 0, 0, 0, 0, 31);
    apply(1, 3, 0, 0, 0, 0, 31);

    // fill: lo tags 1,2 (len 3,7), hi tags 9,10
    cur_req = "R6";
    apply(1, 7, 1, 0, 3, 1, 31);
    apply(0, 0, 1, 1, 5, 9, 31);
    apply(0, 0, 1, 0, 7, 2, 31);
    apply(0, 0, 1, 1, 0, 10, 31);
    idle(31);

    cur_req = "R1";
    for (int s = 0; s < 8; s++) apply(0, s, 0, 0, 0, 0, 31);

    cur_req = "R9";
    for (int f = 0; f < 12; f++) idle(f);

    cur_req = "R3";
    apply(1, 2, 0, 0, 0, 0, 8);
    apply(1, 3, 0, 0, 0, 0, 8);

    cur_req = "R5";
    for (int s = 4; s < 7; s++) apply(1, s, 0, 0, 0, 0, 8);

    cur_req = "R7";
    apply(1, 1, 0, 0, 0, 0, 8);
    apply(1, 0, 0, 0, 0, 0, 8);
    apply(1, 0, 1, 0, 1, 5, 8);
    cur_req = "R2";
    apply(1, 1, 1, 1, 0, 11, 1);
    cur_req = "R9";
    for (int f = 0; f < 4; f++) idle(f);
    cur_req = "R7";
    apply(1, 0, 0, 0, 0, 0, 2);
    apply(1, 1, 0, 0, 0, 0, 2);
    cur_req = "R12";
    idle(0);

    cur_req = "R8";
    apply(1, 0, 0, 0, 0, 0, 31);
    idle(31);
    cur_req = "R11";
    for (int s = 0; s < 8; s++) apply(1, s, 0, 0, 0, 0, 31);
    do_reset();

    cur_req = "R8";
    apply(1, 1, 0, 0, 0, 0, 31);
    idle(31);
    do_reset();

    cur_req = "R10";
    apply(1, 7, 1, 0, 6, 3, 31);
    apply(0, 0, 1, 1, 7, 4, 2);
    apply(1, 1, 0, 0, 0, 0, 2);
    idle(2);
    apply(1, 0, 0, 0, 0, 0, 2);
    idle(2);
    do_reset();

    cur_req = "R6";
    for (int i = 0; i < 4; i++) apply(0, 0, 1, i[0], i, i + 1, 31);
    apply(0, 0, 1, 0, 0, 12, 31);
    idle(31);
    apply(1, 0, 1, 1, 0, 13, 31);
    apply(1, 1, 0, 0, 0, 0, 31);
    apply(1, 1, 0, 0, 0, 0, 31);
    idle(31);
    do_reset();

    cur_req = "R2";
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 499) do_reset();
      apply(($urandom % 4) != 0, $urandom % 8, ($urandom % 3) == 0,
            $urandom % 2, $urandom % 8, $urandom % 16, $urandom % 12);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule